// File: doc/BRIEF.md
# Touchscreen Conversion Sequencer

This block decides when a resistive touchscreen and sensor controller runs a set of ADC conversions. It also records which results are waiting to be read. A 4-bit scan mode, taken from the control fields, selects the channels of a conversion set. The mode also sets two things: whether the set waits for the pen to touch the panel, and whether it runs once or repeats. A conversion set takes a fixed number of clock cycles. When it finishes, the block ORs a mode-specific mask into a 16-bit data-available flag word. When software reads a result, the strobe clears that result's own flag bit.

A single interrupt pin reports pen and data state. Three selectable rules drive it: the raw pen-down level, "any flag set", or "pen down and nothing pending". The pin is always low while the sequencer is disabled. The raw 16-bit result comes from a stub input. The block cuts that result to the resolution that was latched when the conversion set started. The analog front end and the conversion arithmetic are outside this block.

Top module: `touch_conv_seq`

## Requirements
- R1: After reset the flag word is 0, busy is low, the sequencer is disabled, the interrupt is low, the interrupt rule is 2, and the pending mode and resolution codes are 0.
- R2: A conversion set starts only on a cycle where the sequencer is enabled, not busy, and has no control write. Mode codes 0, 13, 14 and 15 never start one.
- R3: Modes 1 (X/Y), 2 (X/Y/Z), 3 (X), 4 (Y) and 5 (Z) start a conversion set only while pen_down is high. Mode 1 repeats for as long as the pen stays down.
- R4: When a conversion set completes, the block ORs a mask into the flag word. The mask depends on the mode: 1→0x0600, 2→0x0780, 3→0x0400, 4→0x0200, 5→0x0180, 6 (battery A)→0x0040, 7 (battery B)→0x0030, 8 (auxiliary)→0x0010, 9 (repeating auxiliary)→0x0010, 10 (temperature A)→0x0004, 11 (repeating port scan)→0x0070, 12 (temperature B)→0x0002. Flags rise at no other time.
- R5: busy rises on the clock edge that starts a set and stays high for exactly CONV_CYCLES cycles. The flags update on the edge where busy falls.
- R6: The single-shot modes (3, 4, 5, 6, 7, 8, 10, 12) clear the enable once any flag is set, so at most one set runs. This holds even if flags were already set before enabling. Modes 9 and 11 keep restarting.
- R7: A control write with enable low, made while busy, cancels the running set. busy is low on the next cycle and no flags are added.
- R8: A read strobe with rd_sel = k, for k from 0 to 10, clears flag bit 10−k. The mapping is: 0 X→bit 10, 1 Y→9, 2 Z1→8, 3 Z2→7, 4 battery A→6, 5 battery B→5, 6 aux A→4, 7 aux B→3, 8 temperature A→2, 9 temperature B→1, 10 DAC→0. rd_sel from 11 to 15 has no effect.
- R9: The interrupt is registered one cycle behind its inputs. Rule 0 gives pen_down. Rule 1 gives "any flag set". Rules 2 and 3 give pen_down AND "no flag set".
- R10: While the sequencer is disabled the interrupt is low, whatever the pen and flag state.
- R11: result equals raw_sample shifted right by (16 − bits). Resolution code 0, 1, 2 and 3 gives 12, 8, 10 and 12 bits. The code used is the one latched when the current set started, so a later control write does not change it.
- R12: A control write loads the enable, pending mode, pending resolution and interrupt rule. The pending mode and resolution take effect at the next start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pen_down | input | 1 | Pen touching the panel |
| cfg_wr | input | 1 | Control write strobe |
| cfg_enable | input | 1 | Enable value for a control write |
| cfg_mode | input | 4 | Pending scan-mode code |
| cfg_res | input | 2 | Pending resolution code |
| cfg_irq_rule | input | 2 | Interrupt pin rule |
| rd_en | input | 1 | Result read strobe |
| rd_sel | input | 4 | Which result is read |
| raw_sample | input | 16 | Raw result from the converter stub |
| result | output | 16 | Raw result cut to the latched resolution |
| flags | output | 16 | Data-available flag word |
| busy | output | 1 | Conversion set in progress |
| enabled | output | 1 | Sequencer enable state |
| irq | output | 1 | Pen/data interrupt level |

## Verification
A wrong delay count shows at the ports as a busy pulse of the wrong length. Scored completions then arrive at the wrong cycle or not at all. A wrong mode decode shows as a wrong flag word at the edge where busy falls, so each conversion set is judged within CONV_CYCLES + 1 cycles of its start. A stuck enable or a bad single-shot rule shows either as extra, unscored completions or as `enabled` failing to drop within two cycles. A bad interrupt rule shows on `irq` one cycle after the pen or flag change.

// File: rtl/tcs_pkg.sv
package tcs_pkg;

   localparam int FLAG_W = 16;
   localparam int MODE_W = 4;
   localparam int RES_W  = 2;
   localparam int RULE_W = 2;
   localparam int SEL_W  = 4;
   localparam int LAST_SEL = 10;

   typedef enum logic [MODE_W-1:0] {
      SM_IDLE     = 4'd0,
      SM_XY       = 4'd1,
      SM_XYZ      = 4'd2,
      SM_X        = 4'd3,
      SM_Y        = 4'd4,
      SM_Z        = 4'd5,
      SM_BATT_A   = 4'd6,
      SM_BATT_B   = 4'd7,
      SM_AUX      = 4'd8,
      SM_AUX_RPT  = 4'd9,
      SM_TEMP_A   = 4'd10,
      SM_PORT_RPT = 4'd11,
      SM_TEMP_B   = 4'd12,
      SM_DRIVE_0  = 4'd13,
      SM_DRIVE_1  = 4'd14,
      SM_DRIVE_2  = 4'd15
   } scan_mode_e;

   typedef enum logic [RULE_W-1:0] {
      IR_PEN        = 2'd0,
      IR_DATA       = 2'd1,
      IR_PEN_IDLE   = 2'd2,
      IR_PEN_IDLE_B = 2'd3
   } irq_rule_e;

   typedef struct packed {
      logic [FLAG_W-1:0] mask;
      logic              runs;
      logic              need_pen;
      logic              one_shot;
   } mode_info_t;

   function automatic mode_info_t decode_mode(logic [MODE_W-1:0] code);
      mode_info_t i;
      i = '0;
      case (scan_mode_e'(code))
         SM_XY:       begin i.mask = 16'h0600; i.runs = 1'b1; i.need_pen = 1'b1; end
         SM_XYZ:      begin i.mask = 16'h0780; i.runs = 1'b1; i.need_pen = 1'b1; end
         SM_X:        begin i.mask = 16'h0400; i.runs = 1'b1; i.need_pen = 1'b1; i.one_shot = 1'b1; end
         SM_Y:        begin i.mask = 16'h0200; i.runs = 1'b1; i.need_pen = 1'b1; i.one_shot = 1'b1; end
         SM_Z:        begin i.mask = 16'h0180; i.runs = 1'b1; i.need_pen = 1'b1; i.one_shot = 1'b1; end
         SM_BATT_A:   begin i.mask = 16'h0040; i.runs = 1'b1; i.one_shot = 1'b1; end
         SM_BATT_B:   begin i.mask = 16'h0030; i.runs = 1'b1; i.one_shot = 1'b1; end
         SM_AUX:      begin i.mask = 16'h0010; i.runs = 1'b1; i.one_shot = 1'b1; end
         SM_AUX_RPT:  begin i.mask = 16'h0010; i.runs = 1'b1; end
         SM_TEMP_A:   begin i.mask = 16'h0004; i.runs = 1'b1; i.one_shot = 1'b1; end
         SM_PORT_RPT: begin i.mask = 16'h0070; i.runs = 1'b1; end
         SM_TEMP_B:   begin i.mask = 16'h0002; i.runs = 1'b1; i.one_shot = 1'b1; end
         default:     i = '0;
      endcase
      return i;
   endfunction

   function automatic int unsigned res_bits(logic [RES_W-1:0] code);
      case (code)
         2'd1:    return 8;
         2'd2:    return 10;
         default: return 12;
      endcase
   endfunction

endpackage

// File: rtl/tcs_mode_decode.sv
module tcs_mode_decode
   import tcs_pkg::*;
(
   input  logic [MODE_W-1:0] mode,
   output logic [FLAG_W-1:0] mask,
   output logic              runs,
   output logic              need_pen,
   output logic              one_shot
);

   mode_info_t info;

   always_comb begin
      info     = decode_mode(mode);
      mask     = info.mask;
      runs     = info.runs;
      need_pen = info.need_pen;
      one_shot = info.one_shot;
   end

   // A mode that waits for the pen or runs once must be a mode that runs.
   always_comb begin
      p_decode_consistent_r3: assert (runs || (!need_pen && !one_shot && mask == '0))
         else $error("mode decode inconsistent");
   end

endmodule

// File: rtl/tcs_conv_timer.sv
module tcs_conv_timer #(
   parameter int unsigned CYCLES = 8
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   input  logic cancel,
   output logic run,
   output logic done
);

   localparam int unsigned CNT_W = (CYCLES > 1) ? $clog2(CYCLES) : 1;
   localparam logic [CNT_W-1:0] LOAD = CNT_W'(CYCLES - 1);

   generate
      if (CYCLES < 1) begin : g_bad_cycles
         $error("CYCLES must be at least 1");
      end
   endgenerate

   logic             run_q;
   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         run_q <= 1'b0;
         cnt_q <= '0;
      end else if (cancel) begin
         run_q <= 1'b0;
         cnt_q <= '0;
      end else if (start) begin
         run_q <= 1'b1;
         cnt_q <= LOAD;
      end else if (run_q) begin
         if (cnt_q == '0) run_q <= 1'b0;
         else             cnt_q <= cnt_q - 1'b1;
      end
   end

   assign run  = run_q;
   assign done = run_q && (cnt_q == '0) && !cancel;

   p_no_restart_r2: assert property (@(posedge clk) disable iff (!rst_n)
      start |-> !run_q);

   p_count_down_r5: assert property (@(posedge clk) disable iff (!rst_n)
      run_q && (cnt_q != '0) && !cancel |=> run_q && (cnt_q == $past(cnt_q) - 1'b1));

   p_cancel_stops_r7: assert property (@(posedge clk) disable iff (!rst_n)
      cancel |=> !run_q);

endmodule

// File: rtl/tcs_irq_pin.sv
module tcs_irq_pin
   import tcs_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic [RULE_W-1:0] rule,
   input  logic              pen,
   input  logic              any_flag,
   input  logic              enable,
   output logic              irq
);

   logic level;
   logic irq_q;

   always_comb begin
      case (irq_rule_e'(rule))
         IR_PEN:  level = pen;
         IR_DATA: level = any_flag;
         default: level = pen && !any_flag;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) irq_q <= 1'b0;
      else        irq_q <= enable && level;
   end

   assign irq = irq_q;

   p_irq_off_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !enable |=> !irq_q);

   p_data_rule_r9: assert property (@(posedge clk) disable iff (!rst_n)
      enable && (rule == 2'd1) && !any_flag |=> !irq_q);

endmodule

// File: rtl/tcs_result_scale.sv
module tcs_result_scale
   import tcs_pkg::*;
#(
   parameter int unsigned RAW_W     = 16,
   parameter bit          MUX_SHIFT = 1'b1
) (
   input  logic [RAW_W-1:0] raw,
   input  logic [RES_W-1:0] res,
   output logic [RAW_W-1:0] scaled
);

   generate
      if (RAW_W < 12) begin : g_bad_width
         $error("RAW_W must hold a 12-bit result");
      end

      if (MUX_SHIFT) begin : g_mux
         localparam int unsigned SH8  = RAW_W - 8;
         localparam int unsigned SH10 = RAW_W - 10;
         localparam int unsigned SH12 = RAW_W - 12;
         always_comb begin
            case (res)
               2'd1:    scaled = raw >> SH8;
               2'd2:    scaled = raw >> SH10;
               default: scaled = raw >> SH12;
            endcase
         end
      end else begin : g_barrel
         logic [7:0] sh;
         always_comb begin
            sh     = 8'(RAW_W - res_bits(res));
            scaled = raw >> sh;
         end
      end
   endgenerate

endmodule

// File: rtl/touch_conv_seq.sv
module touch_conv_seq
   import tcs_pkg::*;
#(
   parameter int unsigned CONV_CYCLES = 8,
   parameter int unsigned RAW_W       = 16,
   parameter bit          MUX_SHIFT   = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              pen_down,
   input  logic              cfg_wr,
   input  logic              cfg_enable,
   input  logic [MODE_W-1:0] cfg_mode,
   input  logic [RES_W-1:0]  cfg_res,
   input  logic [RULE_W-1:0] cfg_irq_rule,
   input  logic              rd_en,
   input  logic [SEL_W-1:0]  rd_sel,
   input  logic [RAW_W-1:0]  raw_sample,
   output logic [RAW_W-1:0]  result,
   output logic [FLAG_W-1:0] flags,
   output logic              busy,
   output logic              enabled,
   output logic              irq
);

   generate
      if (CONV_CYCLES < 1) begin : g_bad_delay
         $error("CONV_CYCLES must be at least 1");
      end
   endgenerate

   // control state
   logic              en_q;
   logic [MODE_W-1:0] mode_q;
   logic [RES_W-1:0]  res_q;
   logic [RULE_W-1:0] rule_q;
   logic [MODE_W-1:0] cur_mode_q;
   logic [RES_W-1:0]  cur_res_q;
   logic [FLAG_W-1:0] flags_q;

   // decoded views of the pending and the running mode
   logic [FLAG_W-1:0] nxt_mask, cur_mask;
   logic nxt_runs, nxt_need_pen, nxt_one_shot;
   logic cur_runs, cur_need_pen, cur_one_shot;

   tcs_mode_decode u_next_dec (
      .mode     (mode_q),
      .mask     (nxt_mask),
      .runs     (nxt_runs),
      .need_pen (nxt_need_pen),
      .one_shot (nxt_one_shot)
   );

   tcs_mode_decode u_cur_dec (
      .mode     (cur_mode_q),
      .mask     (cur_mask),
      .runs     (cur_runs),
      .need_pen (cur_need_pen),
      .one_shot (cur_one_shot)
   );

   // sequencing decision
   logic busy_w, conv_done, cancel, gate, stop_single, start, any_flag;
   logic [FLAG_W-1:0] clr_mask;

   assign any_flag    = |flags_q;
   assign cancel      = cfg_wr && !cfg_enable && busy_w;
   assign gate        = en_q && !cfg_wr && nxt_runs && (!nxt_need_pen || pen_down);
   assign stop_single = gate && nxt_one_shot && any_flag;
   assign start       = gate && !stop_single && !busy_w;

   always_comb begin
      clr_mask = '0;
      if (rd_en && (rd_sel <= SEL_W'(LAST_SEL)))
         clr_mask[SEL_W'(LAST_SEL) - rd_sel] = 1'b1;
   end

   tcs_conv_timer #(.CYCLES(CONV_CYCLES)) u_timer (
      .clk    (clk),
      .rst_n  (rst_n),
      .start  (start),
      .cancel (cancel),
      .run    (busy_w),
      .done   (conv_done)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         en_q       <= 1'b0;
         mode_q     <= '0;
         res_q      <= '0;
         rule_q     <= RULE_W'(IR_PEN_IDLE);
         cur_mode_q <= '0;
         cur_res_q  <= '0;
         flags_q    <= '0;
      end else begin
         if (cfg_wr) begin
            en_q   <= cfg_enable;
            mode_q <= cfg_mode;
            res_q  <= cfg_res;
            rule_q <= cfg_irq_rule;
         end else if (stop_single) begin
            en_q <= 1'b0;
         end
         if (start) begin
            cur_mode_q <= mode_q;
            cur_res_q  <= res_q;
         end
         flags_q <= (flags_q | (conv_done ? cur_mask : '0)) & ~clr_mask;
      end
   end

   tcs_irq_pin u_irq (
      .clk      (clk),
      .rst_n    (rst_n),
      .rule     (rule_q),
      .pen      (pen_down),
      .any_flag (any_flag),
      .enable   (en_q),
      .irq      (irq)
   );

   tcs_result_scale #(.RAW_W(RAW_W), .MUX_SHIFT(MUX_SHIFT)) u_scale (
      .raw    (raw_sample),
      .res    (cur_res_q),
      .scaled (result)
   );

   assign flags   = flags_q;
   assign busy    = busy_w;
   assign enabled = en_q;

   p_start_gate_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy_w) |-> $past(en_q) && (cur_mode_q inside {[4'd1:4'd12]}));

   p_pen_needed_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy_w) && cur_need_pen |-> $past(pen_down));

   p_flag_source_r4: assert property (@(posedge clk) disable iff (!rst_n)
      ((flags_q & ~$past(flags_q)) != '0) |-> $past(conv_done));

   p_cancel_r7: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_wr && !cfg_enable |=> !busy_w && (flags_q & ~$past(flags_q)) == '0);

   p_read_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
      rd_en && (rd_sel <= 4'd10) |=> flags_q[4'd10 - $past(rd_sel)] == 1'b0);

endmodule

// File: tb/touch_conv_seq_bench.sv
`timescale 1ns/1ps
module touch_conv_seq_bench;

   localparam int D = 8;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        pen_down = 1'b0;
   logic        cfg_wr = 1'b0;
   logic        cfg_enable = 1'b0;
   logic [3:0]  cfg_mode = '0;
   logic [1:0]  cfg_res = '0;
   logic [1:0]  cfg_irq_rule = 2'd2;
   logic        rd_en = 1'b0;
   logic [3:0]  rd_sel = '0;
   logic [15:0] raw_sample = '0;
   logic [15:0] result;
   logic [15:0] flags;
   logic        busy;
   logic        enabled;
   logic        irq;

   int checks = 0;
   int errors = 0;
   logic [15:0] exp_q[$];
   logic busy_prev = 1'b0;

   always #2.5 clk = ~clk;

   touch_conv_seq u_touch_conv_seq (
      .clk(clk), .rst_n(rst_n), .pen_down(pen_down), .cfg_wr(cfg_wr),
      .cfg_enable(cfg_enable), .cfg_mode(cfg_mode), .cfg_res(cfg_res),
      .cfg_irq_rule(cfg_irq_rule), .rd_en(rd_en), .rd_sel(rd_sel),
      .raw_sample(raw_sample), .result(result), .flags(flags), .busy(busy),
      .enabled(enabled), .irq(irq)
   );

   task automatic chk(string req, logic [15:0] got, logic [15:0] exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s got %h expected %h at %0t", req, got, exp, $time);
      end
   endtask

   // monitor: every completion (busy falls while still enabled) is scored
   always @(negedge clk) begin
      if (rst_n) begin
         if (busy_prev && !busy && enabled) begin
            if (exp_q.size() == 0) begin
               chk("R4 unexpected completion", flags, 16'hxxxx);
            end else begin
               logic [15:0] e;
               e = exp_q.pop_front();
               chk("R4 completion flags", flags, e);
            end
         end
         busy_prev = busy;
      end
   end

   task automatic cfg(bit en, int mode, int res, int rule);
      cfg_wr = 1'b1; cfg_enable = en; cfg_mode = 4'(mode);
      cfg_res = 2'(res); cfg_irq_rule = 2'(rule);
      @(negedge clk);
      cfg_wr = 1'b0;
   endtask

   task automatic rd(int sel);
      rd_en = 1'b1; rd_sel = 4'(sel);
      @(negedge clk);
      rd_en = 1'b0;
   endtask

   task automatic idle(int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic wait_done();
      int guard = 0;
      do begin
         @(negedge clk);
         guard++;
      end while (busy && guard < 100);
   endtask

   initial begin
      #(200000 * 5);
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      idle(3);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk("R1 flags", flags, 16'h0);
      chk("R1 busy", 16'(busy), 16'h0);
      chk("R1 enabled", 16'(enabled), 16'h0);
      chk("R1 irq", 16'(irq), 16'h0);

      // single shot battery A, 12 bits, data rule
      raw_sample = 16'h8660;
      exp_q.push_back(16'h0040);
      cfg(1, 6, 0, 1);
      @(negedge clk);
      chk("R5 busy rises one edge after enable", 16'(busy), 16'h1);
      idle(D - 1);
      chk("R5 busy still high at cycle D", 16'(busy), 16'h1);
      @(negedge clk);
      chk("R5 busy low after D cycles", 16'(busy), 16'h0);
      chk("R11 12-bit result", result, 16'h0866);
      idle(3);
      chk("R6 single shot clears enable", 16'(enabled), 16'h0);
      chk("R10 irq low while disabled", 16'(irq), 16'h0);
      chk("R6 no second conversion", 16'(busy), 16'h0);
      rd(4);
      chk("R8 read battery A clears bit 6", flags, 16'h0);

      // X/Y scan waits for pen, rule 2
      raw_sample = 16'hABCD;
      cfg(1, 1, 1, 2);
      idle(15);
      chk("R3 no start without pen", 16'(busy), 16'h0);
      chk("R9 rule2 pen up irq low", 16'(irq), 16'h0);
      exp_q.push_back(16'h0600);
      pen_down = 1'b1;
      @(negedge clk);
      chk("R3 start on pen", 16'(busy), 16'h1);
      chk("R9 rule2 pen down no data irq high", 16'(irq), 16'h1);
      wait_done();
      pen_down = 1'b0;
      chk("R11 8-bit result", result, 16'h00AB);
      idle(12);
      chk("R3 no restart after pen up", 16'(busy), 16'h0);
      chk("R3 flags after X/Y scan", flags, 16'h0600);

      // rule 2 with pending data, switch to no-scan mode
      cfg(1, 0, 0, 2);
      pen_down = 1'b1;
      idle(2);
      chk("R9 rule2 data pending irq low", 16'(irq), 16'h0);
      rd(0);
      chk("R8 read X clears bit 10", flags, 16'h0200);
      rd(1);
      @(negedge clk);
      chk("R9 rule2 data cleared irq high", 16'(irq), 16'h1);
      idle(12);
      chk("R2 mode 0 never starts", 16'(busy), 16'h0);
      // rule 0 follows pen
      cfg(1, 0, 0, 0);
      pen_down = 1'b0;
      idle(2);
      chk("R9 rule0 pen up", 16'(irq), 16'h0);
      pen_down = 1'b1;
      @(negedge clk);
      chk("R9 rule0 pen down", 16'(irq), 16'h1);
      cfg(0, 0, 0, 0);
      @(negedge clk);
      chk("R10 disabled with pen down", 16'(irq), 16'h0);
      cfg(1, 13, 0, 0);
      idle(15);
      chk("R2 drive mode 13 never starts", 16'(busy), 16'h0);
      pen_down = 1'b0;

      // repeating aux scan, then cancel
      raw_sample = 16'h35C0;
      exp_q.push_back(16'h0010);
      exp_q.push_back(16'h0010);
      cfg(1, 9, 0, 1);
      wait_done();
      @(negedge clk);
      chk("R6 repeat mode restarts", 16'(busy), 16'h1);
      wait_done();
      idle(3);
      chk("R6 third set running", 16'(busy), 16'h1);
      chk("R9 rule1 data pending irq high", 16'(irq), 16'h1);
      cfg(0, 9, 0, 1);
      chk("R7 cancel clears busy", 16'(busy), 16'h0);
      idle(2 * D);
      chk("R7 no flags from cancelled set", flags, 16'h0010);
      chk("R7 stays idle", 16'(busy), 16'h0);
      rd(6);
      chk("R8 read aux A clears bit 4", flags, 16'h0);

      // resolution latched at start
      raw_sample = 16'hFFFF;
      exp_q.push_back(16'h0002);
      cfg(1, 12, 2, 1);
      @(negedge clk);
      cfg(1, 12, 0, 1);
      wait_done();
      chk("R11 latched 10-bit result", result, 16'h03FF);
      chk("R12 pending resolution not used mid-set", result, 16'h03FF);
      idle(3);
      rd(9);
      chk("R8 read temperature B clears bit 1", flags, 16'h0);

      // resolution code 3 and ignored reads
      raw_sample = 16'h8C70;
      exp_q.push_back(16'h0004);
      cfg(1, 10, 3, 1);
      wait_done();
      chk("R11 code 3 gives 12 bits", result, 16'h08C7);
      idle(3);
      rd(13);
      chk("R8 select 13 ignored", flags, 16'h0004);
      rd(11);
      chk("R8 select 11 ignored", flags, 16'h0004);

      // single shot with flags already set never runs
      cfg(1, 7, 0, 1);
      idle(4);
      chk("R6 pre-set flags clear enable", 16'(enabled), 16'h0);
      chk("R6 pre-set flags no start", 16'(busy), 16'h0);
      rd(8);
      chk("R8 read temperature A clears bit 2", flags, 16'h0);

      // Z needs pen
      exp_q.push_back(16'h0180);
      cfg(1, 5, 0, 2);
      idle(12);
      chk("R3 Z waits for pen", 16'(busy), 16'h0);
      chk("R12 enable loaded", 16'(enabled), 16'h1);
      pen_down = 1'b1;
      wait_done();
      idle(3);
      chk("R6 Z single shot", 16'(enabled), 16'h0);
      chk("R4 Z flags", flags, 16'h0180);
      pen_down = 1'b0;
      rd(2);
      rd(3);
      chk("R8 Z1 and Z2 reads clear bits 8 and 7", flags, 16'h0);

      idle(4);
      checks++;
      if (exp_q.size() != 0) begin
         errors++;
         $display("FAIL R4 missing completions got %0d expected 0", exp_q.size());
      end
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule